// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wrap

This block sits between the serial protocol engine of a small EEPROM slave and its storage array. The protocol engine hands it a starting word address once the address phase of a write has finished. It then passes each received data byte with a strobe, and finally signals the STOP condition. The block holds the bytes in a page latch and writes nothing to the array while bytes are arriving. After a STOP that follows at least one data byte, it runs a self-timed commit that copies the loaded latch locations into the array through a byte-wide write port.

Only the low offset bits of the address pointer advance after each byte. A burst that is longer than a page, or that starts part way into a page, wraps back to the start of the same page. Later bytes then overwrite earlier ones, so the latch always holds the most recent page's worth of data. A write-protect input sampled at STOP cancels the commit. While the commit runs, the busy output tells the protocol engine to withhold acknowledges, and every strobe from the engine is ignored.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low.
- R2: An address load while idle sets the write pointer to `addr_i` and discards any bytes already in the latch.
- R3: Each accepted byte is stored at the pointer's low 4 bits, and those 4 bits then increment modulo 16. The upper 7 address bits never change because of a byte.
- R4: When more than 16 bytes arrive before STOP, the latch keeps the last 16. Each page offset holds the most recent byte sent to it.
- R5: A burst that starts mid-page and runs past offset 15 continues at offset 0 of the same page. Nothing is written to the next page.
- R6: Nothing is written before STOP. A STOP while idle, with at least one byte loaded and `wp_i` low, raises `busy_o` on the next cycle. `busy_o` then stays high for exactly WRITE_CYCLES cycles.
- R7: During the first 16 busy cycles, busy cycle k writes latch offset k to address {page, k}, with `mem_we_o` high only if offset k was loaded. No write happens outside busy.
- R8: A STOP with `wp_i` high starts no commit, writes nothing, and discards the latched bytes.
- R9: A STOP with no bytes loaded starts no commit. It keeps the pointer, so a later byte without a new address load goes to that address.
- R10: While `busy_o` is high, address loads, bytes and STOPs are ignored, and the pointer is not disturbed.
- R11: After a commit the latch is empty, so a following STOP with no new bytes starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_load_i | input | 1 | Load the starting word address |
| addr_i | input | ADDR_W | Starting word address |
| byte_valid_i | input | 1 | A data byte has been received |
| byte_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | STOP condition seen |
| wp_i | input | 1 | Write protect, high blocks programming |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The hardest case to reach from the ports is a pointer that has wrapped, combined with strobes that arrive during a commit. The latch contents and the pointer are not visible, so the stimulus has to expose them through later commits. One run sends twenty bytes so that four offsets are overwritten. Another starts four bytes short of a page boundary, and the resulting writes show where each byte landed. A third sequence sends an address load, a byte and a STOP while busy is high. After the commit ends, it sends a byte with no new address. That byte must land one past the original pre-commit byte, which shows that the ignored strobes disturbed neither the pointer nor the latch.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef enum logic [0:0] {
      PH_IDLE   = 1'b0,
      PH_COMMIT = 1'b1
   } pwb_phase_e;
endpackage

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr #(
   parameter int ADDR_W = 11,
   parameter int OFS_W  = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    load_i,
   input  logic [ADDR_W-1:0]       load_addr_i,
   input  logic                    step_i,
   output logic [ADDR_W-OFS_W-1:0] page_o,
   output logic [OFS_W-1:0]        ofs_o
);
   localparam int PAGE_W = ADDR_W - OFS_W;

   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         page_q <= '0;
         ofs_q  <= '0;
      end else if (load_i) begin
         page_q <= load_addr_i[ADDR_W-1:OFS_W];
         ofs_q  <= load_addr_i[OFS_W-1:0];
      end else if (step_i) begin
         ofs_q  <= ofs_q + 1'b1;
      end
   end

   assign page_o = page_q;
   assign ofs_o  = ofs_q;

   // R3
   page_fixed_on_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !load_i) |=> $stable(page_o));
   // R3
   ofs_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !load_i) |=> (ofs_o == OFS_W'($past(ofs_o) + 1'b1)));
endmodule

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int OFS_W  = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              wr_en_i,
   input  logic [OFS_W-1:0]  wr_ofs_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [OFS_W-1:0]  rd_ofs_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_loaded_o,
   output logic              any_loaded_o
);
   logic [DEPTH-1:0]  loaded_q;
   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            loaded_q[g] <= 1'b0;
            slot_q[g]   <= '0;
         end else if (clear_i) begin
            loaded_q[g] <= 1'b0;
         end else if (wr_en_i && (wr_ofs_i == OFS_W'(g))) begin
            loaded_q[g] <= 1'b1;
            slot_q[g]   <= wr_data_i;
         end
      end
   end

   assign rd_data_o    = slot_q[rd_ofs_i];
   assign rd_loaded_o  = loaded_q[rd_ofs_i];
   assign any_loaded_o = |loaded_q;

   // R3
   byte_marks_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !clear_i) |=> any_loaded_o);
   // R11
   clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> !any_loaded_o);
endmodule

// File: rtl/pwb_commit_timer.sv
module pwb_commit_timer
   import pwb_pkg::*;
#(
   parameter int CYCLES = 40,
   parameter int CNT_W  = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             launch_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] step_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   pwb_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (phase_q == PH_IDLE) begin
         if (launch_i) begin
            phase_q <= PH_COMMIT;
            cnt_q   <= '0;
         end
      end else if (cnt_q == LAST) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign busy_o = (phase_q == PH_COMMIT);
   assign done_o = busy_o && (cnt_q == LAST);
   assign step_o = cnt_q;

   // R6
   busy_needs_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(launch_i));
   // R6
   busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !done_o) |=> (busy_o && step_o == CNT_W'($past(step_o) + 1'b1)));
   // R6
   busy_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !busy_o);
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 16,
   parameter int WRITE_CYCLES = 40
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_valid_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              stop_i,
   input  logic              wp_i,
   output logic              busy_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o
);
   localparam int OFS_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFS_W;
   localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);
   localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(PAGE_BYTES);

   if (PAGE_BYTES < 2 || PAGE_BYTES != (1 << OFS_W)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_cycles
      $error("WRITE_CYCLES must cover one sweep of the page latch");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width");
   end

   logic              idle, do_load, do_byte, do_stop, launch, clear;
   logic              busy, done, any_loaded, rd_loaded;
   logic [CNT_W-1:0]  step;
   logic [PAGE_W-1:0] page;
   logic [OFS_W-1:0]  ofs, sweep_ofs;
   logic [DATA_W-1:0] rd_data;

   assign idle      = !busy;
   assign do_load   = addr_load_i && idle;
   assign do_byte   = byte_valid_i && idle && !addr_load_i;
   assign do_stop   = stop_i && idle;
   assign launch    = do_stop && any_loaded && !wp_i;
   assign clear     = do_load || (do_stop && !launch) || done;
   assign sweep_ofs = step[OFS_W-1:0];

   pwb_addr_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(do_load), .load_addr_i(addr_i),
      .step_i(do_byte), .page_o(page), .ofs_o(ofs)
   );

   pwb_page_latch #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES), .OFS_W(OFS_W)) u_latch (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .wr_en_i(do_byte),
      .wr_ofs_i(ofs), .wr_data_i(byte_i), .rd_ofs_i(sweep_ofs),
      .rd_data_o(rd_data), .rd_loaded_o(rd_loaded), .any_loaded_o(any_loaded)
   );

   pwb_commit_timer #(.CYCLES(WRITE_CYCLES), .CNT_W(CNT_W)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch),
      .busy_o(busy), .step_o(step), .done_o(done)
   );

   assign busy_o      = busy;
   assign mem_we_o    = busy && (step < SWEEP_END) && rd_loaded;
   assign mem_addr_o  = {page, sweep_ofs};
   assign mem_wdata_o = rd_data;

   // R7
   write_in_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |-> busy_o);
   // R10
   page_held_in_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> $stable(page));
   // R8
   protect_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && wp_i && !busy_o) |=> !busy_o);
   // R9
   empty_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !busy_o && !any_loaded) |=> !busy_o);
   // R6
   no_stop_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !stop_i) |=> !busy_o);
endmodule

// File: tb/tb_page_write_buffer.sv
module tb_page_write_buffer;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int PB = 16;
   localparam int WC = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ld = 1'b0, bv = 1'b0, stp = 1'b0, wp = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic busy, we;
   logic [AW-1:0] maddr;
   logic [DW-1:0] mdata;

   page_write_buffer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_load_i(ld), .addr_i(addr),
      .byte_valid_i(bv), .byte_i(din), .stop_i(stp), .wp_i(wp),
      .busy_o(busy), .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(mdata)
   );

   always #5 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   int busy_seen = 0, wr_count = 0;
   bit [7:0] seen [int];

   // behavioural reference state
   bit m_busy = 0;
   int m_cnt = 0, m_ptr = 0;
   int m_buf [PB];
   bit m_ld [PB];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit any_ld();
      for (int i = 0; i < PB; i++) if (m_ld[i]) return 1'b1;
      return 1'b0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; m_ptr = 0;
         for (int i = 0; i < PB; i++) begin m_ld[i] = 0; m_buf[i] = 0; end
      end else if (m_busy) begin
         m_cnt++;
         if (m_cnt == WC) begin
            m_busy = 0;
            for (int i = 0; i < PB; i++) m_ld[i] = 0;
         end
      end else if (ld) begin
         m_ptr = addr;
         for (int i = 0; i < PB; i++) m_ld[i] = 0;
      end else if (bv) begin
         m_buf[m_ptr % PB] = din;
         m_ld[m_ptr % PB] = 1;
         m_ptr = (m_ptr / PB) * PB + ((m_ptr + 1) % PB);
      end else if (stp) begin
         if (any_ld() && !wp) begin
            m_busy = 1; m_cnt = 0;
         end else begin
            for (int i = 0; i < PB; i++) m_ld[i] = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit exp_we;
         exp_we = m_busy && (m_cnt < PB) && m_ld[m_cnt % PB];
         chk(busy == m_busy, "R6 busy", busy, m_busy);
         chk(we == exp_we, "R7 write strobe", we, exp_we);
         if (exp_we) begin
            chk(maddr == AW'((m_ptr / PB) * PB + m_cnt), "R7 write address", maddr, (m_ptr / PB) * PB + m_cnt);
            chk(mdata == DW'(m_buf[m_cnt]), "R7 write data", mdata, m_buf[m_cnt]);
         end
         if (we) begin seen[int'(maddr)] = mdata; wr_count++; end
         if (busy) busy_seen++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 50000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic start_at(input int a);
      @(negedge clk); ld = 1; addr = AW'(a);
      @(negedge clk); ld = 0;
   endtask
   task automatic send(input int d);
      @(negedge clk); bv = 1; din = DW'(d);
      @(negedge clk); bv = 0;
   endtask
   task automatic stop_bus(input bit prot);
      @(negedge clk); stp = 1; wp = prot;
      @(negedge clk); stp = 0; wp = 0;
   endtask
   task automatic settle();
      repeat (WC + 4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0, "R1 busy in reset", busy, 0);
      chk(we == 0, "R1 strobe in reset", we, 0);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 0 && we == 0, "R1 after reset", {busy, we}, 0);

      // single byte: R2, R6
      busy_seen = 0; wr_count = 0;
      start_at(11'h123); send(8'hA5);
      chk(wr_count == 0, "R6 no write before stop", wr_count, 0);
      stop_bus(0); settle();
      chk(seen.exists(32'h123) && seen[32'h123] == 8'hA5, "R2 byte at loaded address", seen.exists(32'h123) ? seen[32'h123] : -1, 8'hA5);
      chk(busy_seen == WC, "R6 busy length", busy_seen, WC);
      chk(wr_count == 1, "R7 only loaded slot written", wr_count, 1);

      // short page write: R3
      start_at(11'h500); send(8'h01); send(8'h02); send(8'h03); stop_bus(0); settle();
      chk(seen.exists(32'h502) && seen[32'h502] == 8'h03, "R3 offset advance", seen.exists(32'h502) ? seen[32'h502] : -1, 8'h03);

      // overflow: R4
      start_at(11'h240);
      for (int i = 0; i < 20; i++) send(8'h10 + i);
      stop_bus(0); settle();
      chk(seen[32'h240] == 8'h20, "R4 overwritten offset 0", seen[32'h240], 8'h20);
      chk(seen[32'h243] == 8'h23, "R4 overwritten offset 3", seen[32'h243], 8'h23);
      chk(seen[32'h245] == 8'h15, "R4 kept offset 5", seen[32'h245], 8'h15);

      // mid-page wrap: R5
      wr_count = 0;
      start_at(11'h3FC);
      for (int i = 0; i < 6; i++) send(8'h80 + i);
      stop_bus(0); settle();
      chk(seen[32'h3F1] == 8'h85, "R5 wrap to page start", seen[32'h3F1], 8'h85);
      chk(!seen.exists(32'h400), "R5 next page untouched", seen.exists(32'h400), 0);
      chk(wr_count == 6, "R7 loaded slot count", wr_count, 6);

      // write protect: R8
      busy_seen = 0;
      start_at(11'h050); send(8'h77); stop_bus(1); settle();
      chk(busy_seen == 0, "R8 protect no busy", busy_seen, 0);
      chk(!seen.exists(32'h050), "R8 protect no write", seen.exists(32'h050), 0);
      stop_bus(0); settle();
      chk(busy_seen == 0, "R8 latch discarded", busy_seen, 0);

      // address only: R9
      start_at(11'h1A7); stop_bus(0); settle();
      chk(busy_seen == 0, "R9 empty stop no busy", busy_seen, 0);
      send(8'h3C); stop_bus(0); settle();
      chk(seen[32'h1A7] == 8'h3C, "R9 pointer kept", seen[32'h1A7], 8'h3C);

      // ignored while busy: R10, R11
      start_at(11'h600); send(8'h11); stop_bus(0);
      start_at(11'h700); send(8'h99); stop_bus(0);
      settle();
      chk(!seen.exists(32'h700), "R10 load and byte ignored", seen.exists(32'h700), 0);
      chk(seen[32'h600] == 8'h11, "R10 committed data intact", seen[32'h600], 8'h11);
      busy_seen = 0;
      stop_bus(0); settle();
      chk(busy_seen == 0, "R11 latch empty after commit", busy_seen, 0);
      send(8'h22); stop_bus(0); settle();
      chk(seen.exists(32'h601) && seen[32'h601] == 8'h22, "R10 pointer undisturbed", seen.exists(32'h601) ? seen[32'h601] : -1, 8'h22);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule